// File: doc/BRIEF.md
# System Power Mode Controller

This block steps a chip between four operating modes that trade speed for power. In full-speed mode the system runs from the prescaled frequency synthesizer. In slow mode it runs from the crystal oscillator. Two further modes run from the always-on internal ring oscillator: a doze mode and a deep low-power mode. The controller owns three things: the enables of the crystal oscillator and the synthesizer, the select code handed to the clock multiplexer, and four power-saving controls. It never moves the clock select onto an oscillator that has not settled. It never switches off an oscillator while the select still points at it.

Mode changes come from three places. The CPU posts a single-cycle request. An external active-low pin enters and leaves low-power mode on its edges. A timer tick wakes the system from low-power mode. On entry to low-power mode, a four-bit mask chosen by software is captured. The mask picks which savings apply: turning the analog front end off, stopping the external clock sources, gating all digital clocks, and powering down the SRAMs. On wake, the controller returns to the mode that was active before entry.

Top module: `pmc_power_mode_ctrl`

## Requirements
- R1: After synchronous reset the block reports slow mode (code 1) with select code 1 (crystal), crystal enabled, synthesizer disabled, every power-saving output low and busy low.
- R2: Mode codes are 0 full-speed, 1 slow, 2 doze and 3 low-power. Select codes are 0 synthesizer, 1 crystal and 2 ring oscillator. Whenever the block is idle, the select code matches the current mode: full-speed→0, slow→1, doze and low-power→2.
- R3: When a target mode needs an oscillator that is off, the oscillator is enabled on the edge that accepts the request. The select code then changes exactly `settle_len`+2 edges after that edge. When nothing needs enabling, the select code changes on the edge after acceptance.
- R4: An oscillator is disabled only on the edge after the select code has moved off it. The synthesizer is never off while the select code is 0, and the crystal is switched off only while the select code is 2.
- R5: Oscillators kept after a transition depend on the mode. Full-speed keeps both. Slow keeps only the crystal. Doze turns the synthesizer off, and also turns the crystal off when `doze_xtal_off` is 1. Low-power turns both off when mask bit 1 is set, and otherwise leaves them as they were.
- R6: Mask bits are bit 0 front-end off, bit 1 external clocks off, bit 2 clock gating and bit 3 SRAM power-down. The mask is captured on the entry edge. Outputs `afe_off`, `clk_gate` and `sram_pd` rise on the edge that moves the select into low-power mode. They fall on the edge that accepts a wake.
- R7: Low-power mode is entered on a CPU request with mode 3, or on a falling edge of `lp_pin_n`. A pin falling edge takes priority over a CPU request in the same cycle.
- R8: In low-power mode, any CPU request (mode field ignored), a rising edge of `lp_pin_n`, or `timer_tick` starts a wake back to the mode held before entry.
- R9: Requests and pin edges arriving while busy are dropped. A CPU request for the current mode is ignored. A timer tick or pin rising edge outside low-power mode has no effect.
- R10: Changing `lp_mask` while in low-power mode leaves the power-saving outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Single-cycle CPU mode request |
| cpu_req_mode | input | 2 | Requested mode code |
| lp_pin_n | input | 1 | External low-power pin, active low, synchronous |
| timer_tick | input | 1 | Timer wake pulse |
| lp_mask | input | 4 | Power-saving action mask for low-power mode |
| doze_xtal_off | input | 1 | Stop the crystal in doze mode |
| settle_len | input | CNT_W | Oscillator settling wait in cycles |
| clk_sel | output | 2 | Clock source select code |
| xtal_en | output | 1 | Crystal oscillator enable |
| synth_en | output | 1 | Frequency synthesizer enable |
| afe_off | output | 1 | Analog front-end disable |
| clk_gate | output | 1 | Gate all digital clocks |
| sram_pd | output | 1 | SRAM power-down |
| cur_mode | output | 2 | Current mode code |
| busy | output | 1 | Transition in progress |

## Verification
The bench builds the block with the default 8-bit settle counter. It drives `settle_len` at 5 and at 0, so both the counted wait and the zero-wait path are exercised, including the single settle cycle that a zero length still costs. A behavioural reference model predicts every output each cycle. Directed sequences walk all four modes, all three wake sources, pin-over-CPU priority, dropped requests while busy, and both settings of the external-clock mask bit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SLOW   = 2'd1,
        MODE_DOZE   = 2'd2,
        MODE_LOWP   = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        SRC_SYNTH = 2'd0,
        SRC_XTAL  = 2'd1,
        SRC_RING  = 2'd2
    } csrc_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_SWITCH,
        PH_TRIM
    } phase_e;

    typedef struct packed {
        logic synth;
        logic xtal;
    } osc_en_t;

    localparam int MASK_W = 4;

    typedef struct packed {
        logic sram_pd;
        logic clk_gate;
        logic ext_off;
        logic afe_off;
    } lp_mask_t;

    function automatic csrc_e mode_src(pmode_e m);
        case (m)
            MODE_NORMAL: return SRC_SYNTH;
            MODE_SLOW:   return SRC_XTAL;
            default:     return SRC_RING;
        endcase
    endfunction

    function automatic osc_en_t mode_need(pmode_e m);
        osc_en_t n;
        n.synth = (m == MODE_NORMAL);
        n.xtal  = (m == MODE_NORMAL) || (m == MODE_SLOW);
        return n;
    endfunction

    function automatic osc_en_t mode_keep(pmode_e m, osc_en_t cur,
                                          logic doze_xoff, logic ext_off);
        osc_en_t k;
        case (m)
            MODE_NORMAL: k = '{synth: 1'b1, xtal: 1'b1};
            MODE_SLOW:   k = '{synth: 1'b0, xtal: 1'b1};
            MODE_DOZE:   k = '{synth: 1'b0, xtal: cur.xtal & ~doze_xoff};
            default:     k = ext_off ? '{synth: 1'b0, xtal: 1'b0} : cur;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
    import pmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cpu_req_valid,
    input  pmode_e cpu_req_mode,
    input  logic   lp_pin_n,
    input  logic   timer_tick,
    input  pmode_e cur_mode,
    input  pmode_e saved_mode,
    input  logic   idle,
    output logic   go,
    output pmode_e go_mode
);
    logic pin_q;
    logic pin_fall;
    logic pin_rise;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= lp_pin_n;
    end

    assign pin_fall = pin_q & ~lp_pin_n;
    assign pin_rise = ~pin_q & lp_pin_n;

    always_comb begin
        go      = 1'b0;
        go_mode = cur_mode;
        if (idle) begin
            if (cur_mode == MODE_LOWP) begin
                if (cpu_req_valid || pin_rise || timer_tick) begin
                    go      = 1'b1;
                    go_mode = saved_mode;
                end
            end else if (pin_fall) begin
                go      = 1'b1;
                go_mode = MODE_LOWP;
            end else if (cpu_req_valid && (cpu_req_mode != cur_mode)) begin
                go      = 1'b1;
                go_mode = cpu_req_mode;
            end
        end
    end

    // R7: a pin falling edge accepted while idle always targets low-power
    a_r7_pin_enters_lp: assert property (@(posedge clk) disable iff (rst)
        (idle && pin_fall && cur_mode != MODE_LOWP) |-> (go && go_mode == MODE_LOWP));

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (start) cnt <= '0;
        else if (run && !done) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt >= len);

endmodule

// File: rtl/pmc_lp_ctrl.sv
module pmc_lp_ctrl
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [MASK_W-1:0] mask_in,
    input  logic              activate,
    input  logic              drop,
    output logic              ext_off,
    output logic              afe_off,
    output logic              clk_gate,
    output logic              sram_pd
);
    lp_mask_t mask_q;
    logic     act;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            act    <= 1'b0;
        end else begin
            if (capture) mask_q <= lp_mask_t'(mask_in);
            if (activate)  act <= 1'b1;
            else if (drop) act <= 1'b0;
        end
    end

    assign ext_off  = mask_q.ext_off;
    assign afe_off  = act & mask_q.afe_off;
    assign clk_gate = act & mask_q.clk_gate;
    assign sram_pd  = act & mask_q.sram_pd;

    // R10: savings stay fixed while active and not being dropped
    a_r10_mask_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(act) && act && !capture) |-> $stable({afe_off, clk_gate, sram_pd}));

endmodule

// File: rtl/pmc_power_mode_ctrl.sv
module pmc_power_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req_valid,
    input  logic [1:0]       cpu_req_mode,
    input  logic             lp_pin_n,
    input  logic             timer_tick,
    input  logic [3:0]       lp_mask,
    input  logic             doze_xtal_off,
    input  logic [CNT_W-1:0] settle_len,
    output logic [1:0]       clk_sel,
    output logic             xtal_en,
    output logic             synth_en,
    output logic             afe_off,
    output logic             clk_gate,
    output logic             sram_pd,
    output logic [1:0]       cur_mode,
    output logic             busy
);
    phase_e  phase;
    pmode_e  mode_q, tgt_q, saved_q;
    csrc_e   sel_q;
    osc_en_t osc_q;

    logic    go;
    pmode_e  go_mode;
    osc_en_t need_w;
    logic    missing;
    logic    t_start, t_run, t_done;
    logic    capture, activate, drop, ext_off;

    pmc_req_decode u_dec (
        .clk           (clk),
        .rst           (rst),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_mode  (pmode_e'(cpu_req_mode)),
        .lp_pin_n      (lp_pin_n),
        .timer_tick    (timer_tick),
        .cur_mode      (mode_q),
        .saved_mode    (saved_q),
        .idle          (phase == PH_IDLE),
        .go            (go),
        .go_mode       (go_mode)
    );

    assign need_w  = mode_need(go_mode);
    assign missing = |(need_w & ~osc_q);
    assign t_start = go && missing;
    assign t_run   = (phase == PH_SETTLE);
    assign capture  = go && (go_mode == MODE_LOWP);
    assign drop     = go && (mode_q == MODE_LOWP);
    assign activate = (phase == PH_SWITCH) && (tgt_q == MODE_LOWP);

    pmc_settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (t_start),
        .run   (t_run),
        .len   (settle_len),
        .done  (t_done)
    );

    pmc_lp_ctrl u_lp (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .mask_in  (lp_mask),
        .activate (activate),
        .drop     (drop),
        .ext_off  (ext_off),
        .afe_off  (afe_off),
        .clk_gate (clk_gate),
        .sram_pd  (sram_pd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            mode_q  <= MODE_SLOW;
            tgt_q   <= MODE_SLOW;
            saved_q <= MODE_SLOW;
            sel_q   <= SRC_XTAL;
            osc_q   <= '{synth: 1'b0, xtal: 1'b1};
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        tgt_q <= go_mode;
                        osc_q <= osc_en_t'(osc_q | need_w);
                        if (go_mode == MODE_LOWP) saved_q <= mode_q;
                        phase <= missing ? PH_SETTLE : PH_SWITCH;
                    end
                end
                PH_SETTLE: begin
                    if (t_done) phase <= PH_SWITCH;
                end
                PH_SWITCH: begin
                    sel_q  <= mode_src(tgt_q);
                    mode_q <= tgt_q;
                    phase  <= PH_TRIM;
                end
                default: begin
                    osc_q <= mode_keep(mode_q, osc_q, doze_xtal_off, ext_off);
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    assign clk_sel  = sel_q;
    assign xtal_en  = osc_q.xtal;
    assign synth_en = osc_q.synth;
    assign cur_mode = mode_q;
    assign busy     = (phase != PH_IDLE);

    // R2: idle select matches mode
    a_r2_sel_matches_mode: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (clk_sel == mode_src(mode_q)));
    // R4: synthesizer never off while selected
    a_r4_synth_live: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == SRC_SYNTH) |-> (synth_en && xtal_en));
    // R4: crystal stops only with ring selected
    a_r4_xtal_late: assert property (@(posedge clk) disable iff (rst)
        $fell(xtal_en) |-> (clk_sel == SRC_RING));
    // R4: synthesizer stops only after select left it
    a_r4_synth_late: assert property (@(posedge clk) disable iff (rst)
        $fell(synth_en) |-> (clk_sel != SRC_SYNTH));
    // R6: power-saving outputs only in low-power mode
    a_r6_savings_in_lp: assert property (@(posedge clk) disable iff (rst)
        (afe_off || clk_gate || sram_pd) |-> (mode_q == MODE_LOWP));

endmodule

// File: tb/pmc_power_mode_ctrl_tb_top.sv
module pmc_power_mode_ctrl_tb_top;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req_valid = 1'b0;
    logic [1:0] cpu_req_mode = 2'd1;
    logic lp_pin_n = 1'b1;
    logic timer_tick = 1'b0;
    logic [3:0] lp_mask = 4'd0;
    logic doze_xtal_off = 1'b0;
    logic [CNT_W-1:0] settle_len = 8'd5;
    logic [1:0] clk_sel, cur_mode;
    logic xtal_en, synth_en, afe_off, clk_gate, sram_pd, busy;

    always #10 clk = ~clk;

    pmc_power_mode_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_req_mode(cpu_req_mode),
        .lp_pin_n(lp_pin_n), .timer_tick(timer_tick), .lp_mask(lp_mask),
        .doze_xtal_off(doze_xtal_off), .settle_len(settle_len), .clk_sel(clk_sel),
        .xtal_en(xtal_en), .synth_en(synth_en), .afe_off(afe_off), .clk_gate(clk_gate),
        .sram_pd(sram_pd), .cur_mode(cur_mode), .busy(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mode, m_sel, m_tgt, m_saved, m_phase, m_wait;
    bit m_xtal, m_synth, m_lpact, m_pinq;
    logic [3:0] m_mask;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 1; m_sel = 1; m_tgt = 1; m_saved = 1; m_phase = 0; m_wait = 0;
            m_xtal = 1; m_synth = 0; m_lpact = 0; m_pinq = 1; m_mask = 0;
        end else begin
            bit fall, rise, go, ns, nx;
            int gm;
            fall = m_pinq && !lp_pin_n;
            rise = !m_pinq && lp_pin_n;
            go = 0; gm = m_mode;
            if (m_phase == 0) begin
                if (m_mode == 3) begin
                    if (cpu_req_valid || rise || timer_tick) begin
                        go = 1; gm = m_saved; m_lpact = 0;
                    end
                end else if (fall) begin
                    go = 1; gm = 3;
                end else if (cpu_req_valid && int'(cpu_req_mode) != m_mode) begin
                    go = 1; gm = int'(cpu_req_mode);
                end
                if (go) begin
                    ns = (gm == 0); nx = (gm <= 1);
                    if (gm == 3) begin m_saved = m_mode; m_mask = lp_mask; end
                    m_tgt = gm;
                    if ((ns && !m_synth) || (nx && !m_xtal)) begin
                        m_wait = 0; m_phase = 1;
                    end else m_phase = 2;
                    m_synth = m_synth | ns; m_xtal = m_xtal | nx;
                end
            end else if (m_phase == 1) begin
                if (m_wait >= int'(settle_len)) m_phase = 2;
                else m_wait++;
            end else if (m_phase == 2) begin
                m_mode = m_tgt;
                m_sel = (m_tgt == 0) ? 0 : (m_tgt == 1) ? 1 : 2;
                if (m_tgt == 3) m_lpact = 1;
                m_phase = 3;
            end else begin
                case (m_mode)
                    0: begin m_synth = 1; m_xtal = 1; end
                    1: begin m_synth = 0; m_xtal = 1; end
                    2: begin m_synth = 0; m_xtal = m_xtal && !doze_xtal_off; end
                    default: if (m_mask[1]) begin m_synth = 0; m_xtal = 0; end
                endcase
                m_phase = 0;
            end
            m_pinq = lp_pin_n;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1/R7/R8/R9 mode", cur_mode, m_mode);
            chk("R3/R9 busy", busy, m_phase != 0);
            chk("R2/R3 clk_sel", clk_sel, m_sel);
            chk("R4/R5 xtal_en", xtal_en, m_xtal);
            chk("R4/R5 synth_en", synth_en, m_synth);
            chk("R6/R10 afe_off", afe_off, m_lpact && m_mask[0]);
            chk("R6/R10 clk_gate", clk_gate, m_lpact && m_mask[2]);
            chk("R6/R10 sram_pd", sram_pd, m_lpact && m_mask[3]);
        end
    end

    task automatic req(int m);
        @(negedge clk); cpu_req_valid = 1'b1; cpu_req_mode = 2'(m);
        @(negedge clk); cpu_req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", cur_mode, 1); chk("R1 sel", clk_sel, 1);
        chk("R1 xtal", xtal_en, 1); chk("R1 synth", synth_en, 0);
        chk("R1 savings", {afe_off, clk_gate, sram_pd}, 0); chk("R1 busy", busy, 0);

        // R3 settle timing to full-speed
        @(negedge clk); cpu_req_valid = 1'b1; cpu_req_mode = 2'd0;
        n = 0;
        do begin
            @(negedge clk); cpu_req_valid = 1'b0; n++;
        end while (clk_sel != 2'd0 && n < 100);
        chk("R3 settle edges", n, 5 + 3);
        chk("R3 synth on", synth_en, 1);
        wait_idle();
        chk("R5 normal osc", {synth_en, xtal_en}, 3);

        // R4 synthesizer off one edge after select leaves it
        @(negedge clk); cpu_req_valid = 1'b1; cpu_req_mode = 2'd1;
        n = 0;
        do begin
            @(negedge clk); cpu_req_valid = 1'b0; n++;
        end while (clk_sel != 2'd1 && n < 100);
        chk("R4 synth kept at switch", synth_en, 1);
        @(negedge clk);
        chk("R4 synth off after switch", synth_en, 0);
        wait_idle();

        // R5 doze with crystal stopped
        doze_xtal_off = 1'b1;
        req(2); wait_idle();
        chk("R5 doze xtal", xtal_en, 0); chk("R2 doze sel", clk_sel, 2);
        settle_len = 8'd0;
        req(1); wait_idle();
        chk("R3 slow after doze", cur_mode, 1);
        settle_len = 8'd5;

        // R9 request while busy dropped
        req(0); req(2); wait_idle();
        chk("R9 busy drop", cur_mode, 0);
        req(0); chk("R9 same mode", busy, 0);

        // R7 pin beats cpu request; R6 savings
        lp_mask = 4'b1101;
        @(negedge clk); lp_pin_n = 1'b0; cpu_req_valid = 1'b1; cpu_req_mode = 2'd1;
        @(negedge clk); cpu_req_valid = 1'b0;
        wait_idle();
        chk("R7 pin priority", cur_mode, 3);
        chk("R6 savings", {afe_off, clk_gate, sram_pd}, 7);
        chk("R5 ext kept", synth_en, 1);
        lp_mask = 4'b0000;
        repeat (3) @(negedge clk);
        chk("R10 mask frozen", {afe_off, clk_gate, sram_pd}, 7);

        // R8 timer wake returns to saved mode
        @(negedge clk); timer_tick = 1'b1;
        @(negedge clk); timer_tick = 1'b0;
        wait_idle();
        chk("R8 tick wake", cur_mode, 0);
        chk("R6 savings cleared", {afe_off, clk_gate, sram_pd}, 0);
        @(negedge clk); lp_pin_n = 1'b1;
        @(negedge clk); timer_tick = 1'b1;
        @(negedge clk); timer_tick = 1'b0;
        chk("R9 rise/tick ignored", busy, 0);

        // R5 external clocks off in low-power, pin wake
        lp_mask = 4'b0010;
        req(3); wait_idle();
        chk("R5 lp ext off", {synth_en, xtal_en}, 0);
        @(negedge clk); lp_pin_n = 1'b0;
        @(negedge clk); chk("R8 fall in lp no wake", busy, 0);
        lp_pin_n = 1'b1;
        @(negedge clk); wait_idle();
        chk("R8 pin wake", cur_mode, 0);

        // R8 cpu wake ignores mode field
        lp_mask = 4'b0000;
        req(3); wait_idle();
        req(2); wait_idle();
        chk("R8 cpu wake saved", cur_mode, 0);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule